// File: doc/BRIEF.md
# Hybrid Direct/Buffered Four-Port Switch Core

This block is the switching core of a four-port mesh router. It has two crossbars side by side. The direct crossbar holds nothing: a flit that finds its output free goes straight to that output in the same cycle it arrives. The buffered crossbar keeps a small FIFO at every input/output crosspoint. A flit that cannot take the direct path is written into the crosspoint FIFO of its requested output. Each output then drains its crosspoint FIFOs through a round-robin arbiter.

Each input offers a flit with valid, data and a destination port index that has already been computed upstream. The input takes part in a ready/valid handshake. Each output drives valid and data and samples the ready signal from downstream. The switch controller is combinational logic. In the same cycle it makes the allocation and steers the input demultiplexers and output multiplexers, so that every flit uses exactly one of the two crossbars.

Top module: `hbx_switch`

## Requirements
- R1: Port indices are 0 = North, 1 = East, 2 = South, 3 = West. The 2-bit `in_dest` field of an input selects the output with that index.
- R2: A flit is forwarded in the same cycle it is offered, with `in_ready` high and nothing stored, when three conditions hold. Its output has no buffered flits. It is the only valid input aimed at that output. That output's `out_ready` is high.
- R3: When several valid inputs aim at the same idle output, the lowest index wins and is forwarded directly. Each other input is written into its own crosspoint FIFO for that output, if that FIFO has a free slot.
- R4: While any crosspoint FIFO of an output holds a flit, the output presents a buffered flit. A new flit aimed at that output is stored and not forwarded.
- R5: When an output's `out_ready` is low, no flit aimed at it is forwarded. Its requesters are stored instead. Once `out_valid` is high with `out_ready` low, it stays high in the next cycle.
- R6: Each crosspoint FIFO holds `XP_DEPTH` flits. `in_ready` is low exactly when the flit is not forwarded directly and its target FIFO is full. Fullness is judged on the count at the start of the cycle.
- R7: Each output chooses among its non-empty crosspoint FIFOs in round-robin order. The search starts one index past the last input served, and the pointer starts at 0 after reset.
- R8: An output transfers at most one flit per cycle. Flits from one input to one output leave in the order they were accepted. No flit is lost or duplicated.
- R9: After reset, all crosspoint FIFOs are empty. `out_valid` is low while no input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 4 | Flit offered on each input |
| in_dest | input | 4 x 2 | Destination output index per input |
| in_data | input | 4 x DATA_W | Flit payload per input |
| in_ready | output | 4 | Flit accepted on each input this cycle |
| out_valid | output | 4 | Flit presented on each output |
| out_data | output | 4 x DATA_W | Flit payload per output |
| out_ready | input | 4 | Downstream acceptance per output |

## Verification
Some properties are checked on every cycle by assertions. A FIFO is never written when full or read when empty. Each arbiter grant is one-hot and lands on a requester. An output never moves more than one flit per cycle. A stalled output never drops its valid.

Other behaviour only the bench's scenarios can show. This covers which input wins a contended direct path, the exact round-robin order of the drain, per-pair ordering, and the absence of loss over long random and hotspot runs. The bench shows these by comparing every output and every `in_ready` against a queue-based model on every cycle.

// File: rtl/hbx_pkg.sv
// Shared constants and types for the hybrid switch core.
// Assumes a fixed four-port mesh router; port index order is also the
// fixed priority order of the direct crossbar.
package hbx_pkg;
    localparam int NUM_PORTS = 4;
    localparam int PORT_W    = $clog2(NUM_PORTS);

    typedef logic [PORT_W-1:0] port_idx_t;

    typedef enum logic [PORT_W-1:0] {
        P_NORTH = 2'd0,
        P_EAST  = 2'd1,
        P_SOUTH = 2'd2,
        P_WEST  = 2'd3
    } port_e;
endpackage

// File: rtl/hbx_xp_fifo.sv
// Crosspoint FIFO of the buffered crossbar: DEPTH entries, one push and
// one pop per cycle. Assumes the caller never pushes when full and never
// pops when empty; full is the registered count, not adjusted for a pop.
module hbx_xp_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output logic [DATA_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Payload storage, written only on an accepted push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/hbx_rr_arb.sv
// Round-robin arbiter for one output's crosspoints. The search starts at
// the pointer; when advance is high the pointer moves one past the winner.
// Assumes advance is only raised while some request is present.
module hbx_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 advance,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] grant_idx
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] ptr;

    // Pick the first requester at or after the pointer, wrapping around.
    always_comb begin
        logic found;
        found     = 1'b0;
        grant     = '0;
        grant_idx = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (int'(ptr) + k) % N;
            if (!found && req[c]) begin
                found     = 1'b1;
                grant[c]  = 1'b1;
                grant_idx = IDX_W'(c);
            end
        end
    end

    // Move the pointer past the input just served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (advance)
            ptr <= (grant_idx == IDX_W'(N - 1)) ? '0 : grant_idx + IDX_W'(1);
    end

    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_on_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    p_grant_when_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));
endmodule

// File: rtl/hbx_switch.sv
// Four-port hybrid switch core. A flit takes the direct crossbar when its
// output has no buffered flits, it wins fixed priority (lowest index) and
// out_ready is high; otherwise it is written into its crosspoint FIFO.
// Assumes inputs hold valid, data and dest stable until in_ready is seen.
module hbx_switch
    import hbx_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int XP_DEPTH = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0]              in_valid,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0]  in_dest,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  in_data,
    output logic [NUM_PORTS-1:0]              in_ready,
    output logic [NUM_PORTS-1:0]              out_valid,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  out_data,
    input  logic [NUM_PORTS-1:0]              out_ready
);
    localparam int NP = NUM_PORTS;

    // Crosspoint signals, indexed [input][output].
    logic              xp_push  [NP][NP];
    logic              xp_pop   [NP][NP];
    logic              xp_full  [NP][NP];
    logic              xp_empty [NP][NP];
    logic [DATA_W-1:0] xp_head  [NP][NP];

    // Per-output state and decisions.
    logic [NP-1:0]     pend;
    logic [NP-1:0]     prim_any;
    port_idx_t         prim_idx [NP];
    logic [NP-1:0]     arb_grant [NP];
    port_idx_t         arb_idx   [NP];

    // Per-input decisions.
    logic [NP-1:0]     direct;

    for (genvar gi = 0; gi < NP; gi++) begin : g_xp_in
        for (genvar go = 0; go < NP; go++) begin : g_xp_out
            assign xp_push[gi][go] = in_valid[gi] && (in_dest[gi] == port_idx_t'(go))
                                     && !direct[gi] && !xp_full[gi][go];
            assign xp_pop[gi][go]  = pend[go] && out_ready[go] && arb_grant[go][gi];

            hbx_xp_fifo #(.DATA_W(DATA_W), .DEPTH(XP_DEPTH)) u_xp (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (xp_push[gi][go]),
                .push_data (in_data[gi]),
                .pop       (xp_pop[gi][go]),
                .full      (xp_full[gi][go]),
                .empty     (xp_empty[gi][go]),
                .head      (xp_head[gi][go])
            );
        end
    end

    for (genvar go = 0; go < NP; go++) begin : g_out
        logic [NP-1:0] xp_req;
        logic [NP-1:0] hit;
        logic [NP-1:0] pop_vec;
        logic [NP-1:0] dir_vec;

        // Gather this output's occupied crosspoints and the pops they get.
        always_comb begin
            for (int k = 0; k < NP; k++) begin
                xp_req[k]  = !xp_empty[k][go];
                pop_vec[k] = xp_pop[k][go];
                dir_vec[k] = direct[k] && (in_dest[k] == port_idx_t'(go));
            end
        end

        assign pend[go] = |xp_req;

        hbx_rr_arb #(.N(NP)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (xp_req),
            .advance   (pend[go] && out_ready[go]),
            .grant     (arb_grant[go]),
            .grant_idx (arb_idx[go])
        );

        // Fixed-priority pick among direct requesters: lowest index wins.
        always_comb begin
            prim_any[go] = 1'b0;
            prim_idx[go] = '0;
            for (int k = NP - 1; k >= 0; k--) begin
                hit[k] = in_valid[k] && (in_dest[k] == port_idx_t'(go));
                if (hit[k]) begin
                    prim_any[go] = 1'b1;
                    prim_idx[go] = port_idx_t'(k);
                end
            end
        end

        // Output multiplexer: buffered flits first, else the direct winner.
        always_comb begin
            out_valid[go] = pend[go] || prim_any[go];
            out_data[go]  = pend[go] ? xp_head[arb_idx[go]][go] : in_data[prim_idx[go]];
        end

        p_one_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({pop_vec, dir_vec}) <= 1);
        p_buffered_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
            pend[go] |-> (dir_vec == '0));
        p_keep_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[go] && !out_ready[go]) |=> out_valid[go]);
    end

    for (genvar gi = 0; gi < NP; gi++) begin : g_in
        // An input goes direct when it is the idle, ready output's winner.
        always_comb begin
            port_idx_t d;
            d          = in_dest[gi];
            direct[gi] = in_valid[gi] && prim_any[d] && (prim_idx[d] == port_idx_t'(gi))
                         && !pend[d] && out_ready[d];
            in_ready[gi] = direct[gi] || !xp_full[gi][d];
        end
    end
endmodule

// File: tb/hbx_switch_bench.sv
module hbx_switch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 16;
    localparam int DEPTH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]          in_valid = '0;
    logic [NP-1:0][1:0]     in_dest = '0;
    logic [NP-1:0][DW-1:0]  in_data = '0;
    logic [NP-1:0]          in_ready;
    logic [NP-1:0]          out_valid;
    logic [NP-1:0][DW-1:0]  out_data;
    logic [NP-1:0]          out_ready = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hbx_switch #(.DATA_W(DW), .XP_DEPTH(DEPTH)) u_hbx_switch (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    // Reference model state: queues per [input][output] and rr pointers.
    logic [DW-1:0] q [NP][NP][$];
    int rr [NP];
    bit hv [NP];
    logic [DW-1:0] hd [NP];
    int hdst [NP];
    int gen_rate = 0;
    int fixed_dest = -1;
    int rdy_rate [NP];
    int seq = 0;
    int sent = 0;
    int delivered = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic inject(input int i, input int d);
        hv[i] = 1;
        hdst[i] = d;
        hd[i] = DW'((i << 12) | (seq & 12'hfff));
        seq++;
    endtask

    task automatic step();
        int direct_o [NP];
        int popw [NP];
        bit acc [NP];
        bit dir [NP];
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            in_valid[i] = hv[i];
            in_data[i]  = hd[i];
            in_dest[i]  = 2'(hdst[i]);
        end
        for (int o = 0; o < NP; o++) out_ready[o] = (($urandom % 100) < rdy_rate[o]);
        #1;
        if (!rst_n) return;
        for (int o = 0; o < NP; o++) begin
            bit pend;
            int win;
            int prim;
            int nreq;
            bit ev;
            logic [DW-1:0] ed;
            string tag;
            pend = 0; win = -1; prim = -1; nreq = 0; ed = '0;
            for (int i = 0; i < NP; i++) if (q[i][o].size() > 0) pend = 1;
            for (int k = 0; k < NP; k++) begin
                int c;
                c = (rr[o] + k) % NP;
                if (win < 0 && q[c][o].size() > 0) win = c;
            end
            for (int i = 0; i < NP; i++)
                if (hv[i] && hdst[i] == o) begin
                    nreq++;
                    if (prim < 0) prim = i;
                end
            ev = pend || (nreq > 0);
            if (pend) ed = q[win][o][0];
            else if (prim >= 0) ed = hd[prim];
            if (pend && nreq > 0) tag = "R4";
            else if (pend) tag = "R7";
            else if (nreq > 0 && !out_ready[o]) tag = "R5";
            else if (nreq > 1) tag = "R3";
            else tag = "R2/R1";
            chk(out_valid[o] == ev, tag, $sformatf("out_valid[%0d]", o), 32'(out_valid[o]), 32'(ev));
            if (ev) chk(out_data[o] == ed, tag, $sformatf("out_data[%0d]", o), 32'(out_data[o]), 32'(ed));
            direct_o[o] = (!pend && out_ready[o] && prim >= 0) ? prim : -1;
            popw[o] = (pend && out_ready[o]) ? win : -1;
        end
        for (int i = 0; i < NP; i++) begin
            acc[i] = 0; dir[i] = 0;
            if (hv[i]) begin
                bit er;
                dir[i] = (direct_o[hdst[i]] == i);
                er = dir[i] || (q[i][hdst[i]].size() < DEPTH);
                acc[i] = er;
                chk(in_ready[i] == er, dir[i] ? "R2" : "R6", $sformatf("in_ready[%0d]", i),
                    32'(in_ready[i]), 32'(er));
            end
        end
        for (int o = 0; o < NP; o++)
            if (popw[o] >= 0) begin
                void'(q[popw[o]][o].pop_front());
                rr[o] = (popw[o] + 1) % NP;
                delivered++;
            end
        for (int i = 0; i < NP; i++)
            if (hv[i] && acc[i]) begin
                if (dir[i]) delivered++;
                else q[i][hdst[i]].push_back(hd[i]);
                sent++;
                hv[i] = 0;
            end
        for (int i = 0; i < NP; i++)
            if (!hv[i] && (($urandom % 100) < gen_rate))
                inject(i, (fixed_dest >= 0) ? fixed_dest : int'($urandom % NP));
    endtask

    task automatic set_ready(input int r);
        for (int o = 0; o < NP; o++) rdy_rate[o] = r;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int o = 0; o < NP; o++) rr[o] = 0;
        for (int i = 0; i < NP; i++) begin hv[i] = 0; hd[i] = '0; hdst[i] = 0; end
        set_ready(100);
        rst_n = 0;
        repeat (3) step();
        @(negedge clk);
        rst_n = 1;
        // R9: idle after reset, nothing buffered
        step();
        for (int o = 0; o < NP; o++)
            chk(out_valid[o] == 1'b0, "R9", $sformatf("reset out_valid[%0d]", o), 32'(out_valid[o]), 0);

        // R2 / R1: one flit to each destination index from input 1
        for (int d = 0; d < NP; d++) begin
            inject(1, d);
            step();
        end

        // R3: all four inputs to South at once, then R7 round-robin drain
        for (int i = 0; i < NP; i++) inject(i, 2);
        step();
        inject(0, 2);   // R4: new flit while South still has buffered flits
        repeat (6) step();

        // R5 / R6: East stalled, inputs 0 and 2 keep sending to East
        rdy_rate[1] = 0;
        for (int k = 0; k < 8; k++) begin
            if (!hv[0]) inject(0, 1);
            if (!hv[2]) inject(2, 1);
            step();
        end
        set_ready(100);
        repeat (10) step();

        // R8: random traffic with random backpressure
        gen_rate = 60;
        set_ready(70);
        repeat (3000) step();

        // R7: hotspot on West with full load
        fixed_dest = 3;
        gen_rate = 100;
        set_ready(100);
        repeat (500) step();

        // R8: drain everything and account for every flit
        gen_rate = 0;
        fixed_dest = -1;
        repeat (60) step();
        begin
            int left;
            left = 0;
            for (int i = 0; i < NP; i++) for (int o = 0; o < NP; o++) left += q[i][o].size();
            chk(left == 0, "R8", "model backlog", 32'(left), 0);
            chk(sent == delivered, "R8", "delivered count", 32'(delivered), 32'(sent));
            chk(out_valid == '0, "R8", "out_valid after drain", 32'(out_valid), 0);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule